// File: doc/BRIEF.md
# Two-Input Level Sequence Detector

This block watches two single-bit control levels, `lead_i` and `trail_i`, that are already synchronous to its clock. It takes one sample of the pair on every rising edge. It raises a registered flag when the pair moves from (lead=1, trail=0) to (lead=1, trail=1) on two consecutive edges. Once raised, the flag stays high until an edge samples both inputs low. No other input pattern lowers it.

Internally the block is a three-state Moore machine: idle, armed and held. "Armed" means the last sample was (1,0). The flag is one bit of the state register, so it can only change on a clock edge and it carries no combinational glitches. Both inputs are plain level pins. There is no valid/ready handshake, because every clock edge is a sample and the block never back-pressures its source.

Top module: `pair_seq_detect`

## Requirements
- R1: On a rising edge that samples `rst_i` high, the machine enters idle. The state code is 2'b00 for idle, 2'b01 for armed and 2'b10 for held. `flag_o` reads 0 from that edge until a later set event.
- R2: Write a sample as the pair (lead,trail). While `flag_o` is 0, a rising edge that samples (1,1) drives `flag_o` to 1 on that same edge if the previous edge sampled (1,0).
- R3: While `flag_o` is 1, an edge that samples (0,1), (1,0) or (1,1) leaves `flag_o` at 1.
- R4: While `flag_o` is 1, an edge that samples (0,0) returns `flag_o` to 0 on that edge.
- R5: A sample of (1,1) leaves `flag_o` at 0 when the previous sample was (0,0), (0,1) or (1,1). The same holds when the (1,1) sample is the first edge after reset.
- R6: While `flag_o` is 0, a (1,0) sample arms the machine, and repeated (1,0) samples keep it armed. Thus (1,0),(1,0),(1,1) sets the flag. An armed machine that samples (0,0) or (0,1) disarms, so a following (1,1) does not set the flag.
- R7: Reset is synchronous. Raising `rst_i` between edges does not change `flag_o` before the next rising edge. At that edge, reset overrides any input pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; every rising edge samples the inputs |
| rst_i | input | 1 | Synchronous active-high reset |
| lead_i | input | 1 | First input of the pair (the "1" in 10 and 11) |
| trail_i | input | 1 | Second input of the pair |
| flag_o | output | 1 | Registered detector output |

## Verification
The bench resets the machine and then drives every ordered sequence of four pairs, which gives 256 histories. This sweep covers each pair in every position and after every predecessor. It separates a (1,1) that follows (1,0) from one that follows any other pair or comes first after reset. It also separates a (0,0) clear from the three pairs that must hold the flag, and repeated (1,0) arming from arming that has been broken by (0,0) or (0,1). A further test raises reset between edges while the flag is held. This shows that reset acts only at the edge.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_HELD  = 2'b10
  } det_state_e;

  localparam int unsigned HELD_BIT = 1;

endpackage

// File: rtl/pair_seq_next.sv
module pair_seq_next
  import pair_seq_pkg::*;
(
  input  det_state_e cur_i,
  input  logic       lead_i,
  input  logic       trail_i,
  output det_state_e nxt_o
);

  logic pair_00;
  logic pair_10;
  logic pair_11;

  assign pair_00 = !lead_i && !trail_i;
  assign pair_10 =  lead_i && !trail_i;
  assign pair_11 =  lead_i &&  trail_i;

  always_comb begin
    nxt_o = ST_IDLE;
    unique case (cur_i)
      ST_IDLE: begin
        if (pair_10) nxt_o = ST_ARMED;
        else         nxt_o = ST_IDLE;
      end
      ST_ARMED: begin
        if (pair_11)      nxt_o = ST_HELD;
        else if (pair_10) nxt_o = ST_ARMED;
        else              nxt_o = ST_IDLE;
      end
      ST_HELD: begin
        if (pair_00) nxt_o = ST_IDLE;
        else         nxt_o = ST_HELD;
      end
      default: nxt_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pair_seq_state_reg.sv
module pair_seq_state_reg
  import pair_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  det_state_e nxt_i,
  output det_state_e cur_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) cur_o <= ST_IDLE;
    else       cur_o <= nxt_i;
  end

  // only the three legal codes are ever held
  assert_legal_code_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (cur_o == ST_IDLE));

  assert_onehot_state_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(cur_o));

endmodule

// File: rtl/pair_seq_detect.sv
module pair_seq_detect
  import pair_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic lead_i,
  input  logic trail_i,
  output logic flag_o
);

  det_state_e state_q;
  det_state_e state_d;

  pair_seq_next u_next (
    .cur_i   (state_q),
    .lead_i  (lead_i),
    .trail_i (trail_i),
    .nxt_o   (state_d)
  );

  pair_seq_state_reg u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_i (state_d),
    .cur_o (state_q)
  );

  // flag is a flop bit of the state code: Moore, glitch-free
  assign flag_o = state_q[HELD_BIT];

  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> !flag_o);

  assert_set_after_arm_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_ARMED && lead_i && trail_i) |=> flag_o);

  assert_hold_nonzero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_o && (lead_i || trail_i)) |=> flag_o);

  assert_clear_on_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_o && !lead_i && !trail_i) |=> !flag_o);

  assert_no_set_unarmed_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!flag_o && state_q != ST_ARMED) |=> !flag_o);

  assert_arm_on_10_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!flag_o && lead_i && !trail_i) |=> (state_q == ST_ARMED));

  assert_disarm_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_ARMED && !lead_i) |=> (state_q == ST_IDLE));

endmodule

// File: tb/pair_seq_detect_tb_top.sv
`timescale 1ns/1ps
module pair_seq_detect_tb_top;

  logic clk = 1'b0;
  logic rst;
  logic lead;
  logic trail;
  logic flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model: expected flag and the last sampled pair
  bit exp_flag;
  int prev_pair;   // -1 means no sample since reset

  always #4 clk = ~clk;   // 125 MHz

  pair_seq_detect dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .lead_i  (lead),
    .trail_i (trail),
    .flag_o  (flag)
  );

  task automatic check(input string req, input bit exp);
    n_run++;
    if (flag !== exp) begin
      n_fail++;
      $display("FAIL %s: flag actual=%0b expected=%0b", req, flag, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lead = 1'b1; trail = 1'b1;
    @(posedge clk); #1;
    check("R1", 1'b0);
    @(negedge clk);
    rst = 1'b0;
    exp_flag  = 1'b0;
    prev_pair = -1;
  endtask

  task automatic step(input int p);
    string tag;
    bit nxt;
    @(negedge clk);
    lead  = p[1];
    trail = p[0];
    if (exp_flag) nxt = (p != 0);
    else          nxt = (p == 3) && (prev_pair == 2);
    if (!exp_flag && nxt)       tag = "R2";
    else if (exp_flag && nxt)   tag = "R3";
    else if (exp_flag && !nxt)  tag = "R4";
    else if (p == 3)            tag = "R5";
    else                        tag = "R6";
    @(posedge clk); #1;
    check(tag, nxt);
    exp_flag  = nxt;
    prev_pair = p;
  endtask

  initial begin
    rst = 1'b1; lead = 1'b0; trail = 1'b0;
    exp_flag = 1'b0; prev_pair = -1;
    repeat (2) @(posedge clk);
    #1 check("R1", 1'b0);

    // all 4-pair histories after reset
    for (int s = 0; s < 256; s++) begin
      do_reset();
      for (int k = 3; k >= 0; k--) step((s >> (2 * k)) & 3);
    end

    // R6: repeated 10 keeps the machine armed
    do_reset();
    step(2); step(2); step(2); step(3);

    // R7: reset raised between edges takes effect only at the edge
    do_reset();
    step(2); step(3);
    @(negedge clk);
    rst = 1'b1; lead = 1'b1; trail = 1'b1;
    #1 check("R7", 1'b1);
    @(posedge clk); #1;
    check("R7", 1'b0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule